// File: doc/BRIEF.md
# Prioritized UART Interrupt Identifier

This block gathers the four interrupt causes of a UART into one active-high interrupt line and an 8-bit identification register. The causes are receiver line errors, received data waiting, an empty transmit holding register and a change on the modem inputs. The host sets a 4-bit enable mask. The identification register then reports which enabled cause is pending with the highest priority, as a 2-bit code plus a "nothing pending" flag in bit 0.

The serial datapath raises single-cycle set pulses for the line-error, data-ready and holding-empty causes. The register decoder sends single-cycle or held strobes for the accesses that have side effects. Each cause has its own clear action. The identifier value is frozen for as long as a read of it is held, so the host sees a stable code. The modem cause is kept inside the block: four active-low inputs are synchronized, their levels are reported in a status byte, and their changes are latched as delta bits.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, the identifier reads 0x01, the interrupt line is low, the enable register reads 0x00, and the modem status reads 0x00 while all modem inputs are high.
- R2: Writing the enable register stores bits 3:0 (bit 0 = data ready, bit 1 = holding empty, bit 2 = line errors, bit 3 = modem), and bits 7:4 always read 0.
- R3: The identifier reads 0x06 for line errors, 0x04 for data ready, 0x02 for holding empty, 0x00 for modem, and 0x01 when no enabled cause is pending. Priority runs in that order, and bits 7:3 are always 0.
- R4: Outside an identifier read, the interrupt line is high exactly when some enabled cause is pending.
- R5: Line errors clear on a line-status read, data ready clears on a receive-buffer read, and the modem cause clears on a modem-status read. A set pulse in the same cycle as its clear leaves the cause pending.
- R6: Holding empty clears on a holding-register write, or when an identifier read begins while the identifier reports 0x02. A read that begins while the identifier reports another code leaves it pending.
- R7: While the identifier read strobe is held, the identifier keeps the value it had in the first cycle of the read. Causes that arrive meanwhile appear once the strobe drops.
- R8: Clearing one cause leaves every other pending cause pending.
- R9: Modem bits 0, 1 and 3 set on any change of the synchronized clear-to-send, data-set-ready and carrier-detect inputs. Bit 2 sets only when the ring input goes from low to high.
- R10: Modem bits 4, 5, 6 and 7 read the complement of clear-to-send, data-set-ready, ring and carrier-detect. They change, together with any delta bit, two clocks after the input changes.
- R11: A cause that arrives while disabled is still recorded, and it is reported once its enable bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ier_wr_i | input | 1 | Enable register write strobe |
| ier_wdata_i | input | 4 | Enable register write data |
| ls_set_i | input | 1 | Line error detected (pulse) |
| rx_set_i | input | 1 | Received word loaded (pulse) |
| thre_set_i | input | 1 | Holding register became empty (pulse) |
| lsr_rd_i | input | 1 | Line status register read |
| rbr_rd_i | input | 1 | Receive buffer read |
| thr_wr_i | input | 1 | Holding register write |
| iir_rd_i | input | 1 | Identifier read, held for the access |
| msr_rd_i | input | 1 | Modem status read |
| cts_ni | input | 1 | Clear to send, active low |
| dsr_ni | input | 1 | Data set ready, active low |
| ri_ni | input | 1 | Ring indicator, active low |
| dcd_ni | input | 1 | Carrier detect, active low |
| irq_o | output | 1 | Interrupt request, active high |
| iir_o | output | 8 | Identification register |
| ier_o | output | 8 | Enable register readback |
| msr_o | output | 8 | Modem status register |

## Verification
The embedded assertions check a set of behaviours on every cycle. These are the hold of the identifier during a read, the match between the interrupt line and bit 0 of the identifier outside reads, and that line errors always take the top code. They also cover the per-cause clear and set-wins rules and the cause behind each modem delta bit. Some behaviours appear only in the bench scenarios, which compare every cycle against a behavioural model: the full priority ladder as causes come and go, a higher cause that arrives during a held read and shows up only afterwards, the holding-empty cause surviving a read that reported another code, the two-clock latency of the modem path, and ring being reported only on its trailing edge.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int EN_RX   = 0;
  localparam int EN_THRE = 1;
  localparam int EN_LS   = 2;
  localparam int EN_MS   = 3;

  typedef enum logic [1:0] {
    CODE_MS   = 2'b00,
    CODE_THRE = 2'b01,
    CODE_RX   = 2'b10,
    CODE_LS   = 2'b11
  } irq_code_e;

  typedef struct packed {
    logic ls;
    logic rx;
    logic thre;
    logic ms;
  } irq_src_t;
endpackage

// File: rtl/uart_irq_modem.sv
module uart_irq_modem #(
  parameter int            LINES       = 4,
  parameter int            SYNC_STAGES = 2,
  parameter logic [LINES-1:0] RISE_MASK = 4'b0100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] line_ni,
  input  logic             clr_i,
  output logic [LINES-1:0] state_no,
  output logic [LINES-1:0] delta_o
);
  localparam int LAST = SYNC_STAGES - 1;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   delta_q;
    logic                   hit;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q <= '1;
      else         sync_q <= {sync_q[LAST-1:0], line_ni[g]};
    end

    // event is judged on the stage about to move into the output tap
    if (RISE_MASK[g]) begin : g_rise
      assign hit = !sync_q[LAST] && sync_q[LAST-1];
    end else begin : g_any
      assign hit = sync_q[LAST] != sync_q[LAST-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) delta_q <= 1'b0;
      else         delta_q <= hit | (delta_q & ~clr_i);
    end

    assign state_no[g] = sync_q[LAST];
    assign delta_o[g]  = delta_q;

    if (RISE_MASK[g]) begin : g_chk_rise
      AST_TERI_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(delta_q) |-> (state_no[g] && !$past(state_no[g]))); // R9
    end else begin : g_chk_any
      AST_DELTA_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(delta_q) |-> (state_no[g] != $past(state_no[g]))); // R9
    end

    AST_DELTA_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !hit) |=> !delta_q); // R5
  end
endmodule

// File: rtl/uart_irq_flags.sv
module uart_irq_flags #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic pend_q;

    // a new event outranks a clear in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q <= 1'b0;
      else         pend_q <= set_i[g] | (pend_q & ~clr_i[g]);
    end

    assign pend_o[g] = pend_q;

    AST_FLAG_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[g] && !set_i[g]) |=> !pend_o[g]); // R5
    AST_FLAG_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend_o[g] && !clr_i[g]) |=> pend_o[g]); // R8
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
#(
  parameter int REG_W = 8,
  parameter int EN_W  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  irq_src_t         pend_i,
  input  logic [EN_W-1:0]  en_i,
  input  logic             rd_i,
  output logic [REG_W-1:0] iir_o,
  output logic             irq_o,
  output logic             thre_ack_o
);
  localparam int PAD_W = REG_W - 3;

  irq_src_t         act;
  irq_code_e        code;
  logic             any;
  logic [REG_W-1:0] live;
  logic [REG_W-1:0] snap_q;
  logic             reading_q;

  always_comb begin
    act.ls   = pend_i.ls   & en_i[EN_LS];
    act.rx   = pend_i.rx   & en_i[EN_RX];
    act.thre = pend_i.thre & en_i[EN_THRE];
    act.ms   = pend_i.ms   & en_i[EN_MS];
    any      = act.ls | act.rx | act.thre | act.ms;
    if (act.ls)        code = CODE_LS;
    else if (act.rx)   code = CODE_RX;
    else if (act.thre) code = CODE_THRE;
    else               code = CODE_MS;
    live = {{PAD_W{1'b0}}, code, ~any};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reading_q <= 1'b0;
      snap_q    <= '0;
    end else begin
      reading_q <= rd_i;
      if (rd_i && !reading_q) snap_q <= live;
    end
  end

  assign iir_o      = (rd_i && reading_q) ? snap_q : live;
  assign irq_o      = any;
  assign thre_ack_o = rd_i && !reading_q && any && (code == CODE_THRE);

  AST_IIR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && $past(rd_i)) |-> $stable(iir_o)); // R7
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int EN_W        = 4,
  parameter int REG_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ier_wr_i,
  input  logic [EN_W-1:0]  ier_wdata_i,
  input  logic             ls_set_i,
  input  logic             rx_set_i,
  input  logic             thre_set_i,
  input  logic             lsr_rd_i,
  input  logic             rbr_rd_i,
  input  logic             thr_wr_i,
  input  logic             iir_rd_i,
  input  logic             msr_rd_i,
  input  logic             cts_ni,
  input  logic             dsr_ni,
  input  logic             ri_ni,
  input  logic             dcd_ni,
  output logic             irq_o,
  output logic [REG_W-1:0] iir_o,
  output logic [REG_W-1:0] ier_o,
  output logic [REG_W-1:0] msr_o
);
  localparam int MODEM_N = REG_W / 2;
  localparam int FLAG_N  = 3;

  logic [EN_W-1:0]    ier_q;
  logic [MODEM_N-1:0] state_n;
  logic [MODEM_N-1:0] delta;
  logic [FLAG_N-1:0]  flag_set;
  logic [FLAG_N-1:0]  flag_clr;
  logic [FLAG_N-1:0]  flag_pend;
  logic               thre_ack;
  irq_src_t           pend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ier_q <= '0;
    else if (ier_wr_i) ier_q <= ier_wdata_i;
  end
  assign ier_o = {{(REG_W-EN_W){1'b0}}, ier_q};

  // flag order follows the enable bit order
  assign flag_set = {ls_set_i, thre_set_i, rx_set_i};
  assign flag_clr = {lsr_rd_i, thr_wr_i | thre_ack, rbr_rd_i};

  uart_irq_flags #(.N(FLAG_N)) u_flags (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (flag_set),
    .clr_i  (flag_clr),
    .pend_o (flag_pend)
  );

  uart_irq_modem #(.LINES(MODEM_N), .SYNC_STAGES(SYNC_STAGES), .RISE_MASK(4'b0100)) u_modem (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .line_ni  ({dcd_ni, ri_ni, dsr_ni, cts_ni}),
    .clr_i    (msr_rd_i),
    .state_no (state_n),
    .delta_o  (delta)
  );
  assign msr_o = {~state_n, delta};

  always_comb begin
    pend.ls   = flag_pend[EN_LS];
    pend.rx   = flag_pend[EN_RX];
    pend.thre = flag_pend[EN_THRE];
    pend.ms   = |delta;
  end

  uart_irq_prio #(.REG_W(REG_W), .EN_W(EN_W)) u_prio (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pend_i     (pend),
    .en_i       (ier_q),
    .rd_i       (iir_rd_i),
    .iir_o      (iir_o),
    .irq_o      (irq_o),
    .thre_ack_o (thre_ack)
  );

  AST_LS_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_pend[EN_LS] && ier_q[EN_LS] && !iir_rd_i) |-> (iir_o[2:0] == 3'b110)); // R3
  AST_IRQ_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iir_rd_i |-> (irq_o == !iir_o[0])); // R4
  AST_THRE_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thre_ack && !thre_set_i) |=> !flag_pend[EN_THRE]); // R6
endmodule

// File: tb/uart_irq_ident_test.sv
module uart_irq_ident_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic ier_wr_i = 0, ls_set_i = 0, rx_set_i = 0, thre_set_i = 0;
  logic lsr_rd_i = 0, rbr_rd_i = 0, thr_wr_i = 0, iir_rd_i = 0, msr_rd_i = 0;
  logic cts_ni = 1, dsr_ni = 1, ri_ni = 1, dcd_ni = 1;
  logic [3:0] ier_wdata_i = '0;
  logic       irq_o;
  logic [7:0] iir_o, ier_o, msr_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural reference state
  bit [3:0] m_ier;
  bit       m_ls, m_rx, m_thre;
  bit [3:0] m_d, m_s0, m_s1;
  bit       m_reading;
  bit [7:0] m_snap;

  always #4 clk = ~clk;

  uart_irq_ident uut (
    .clk_i(clk), .rst_ni(rst_ni), .ier_wr_i(ier_wr_i), .ier_wdata_i(ier_wdata_i),
    .ls_set_i(ls_set_i), .rx_set_i(rx_set_i), .thre_set_i(thre_set_i),
    .lsr_rd_i(lsr_rd_i), .rbr_rd_i(rbr_rd_i), .thr_wr_i(thr_wr_i),
    .iir_rd_i(iir_rd_i), .msr_rd_i(msr_rd_i),
    .cts_ni(cts_ni), .dsr_ni(dsr_ni), .ri_ni(ri_ni), .dcd_ni(dcd_ni),
    .irq_o(irq_o), .iir_o(iir_o), .ier_o(ier_o), .msr_o(msr_o)
  );

  function automatic bit [7:0] model_live();
    bit ls = m_ls & m_ier[2];
    bit rx = m_rx & m_ier[0];
    bit th = m_thre & m_ier[1];
    bit ms = (m_d != 0) & m_ier[3];
    if (ls) return 8'h06;
    if (rx) return 8'h04;
    if (th) return 8'h02;
    if (ms) return 8'h00;
    return 8'h01;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    bit [7:0] live;
    bit       ack;
    bit [3:0] in_n;
    bit [7:0] exp_iir;
    @(posedge clk);
    live = model_live();
    ack  = iir_rd_i && !m_reading && (live == 8'h02);
    in_n = {dcd_ni, ri_ni, dsr_ni, cts_ni};
    if (ier_wr_i) m_ier = ier_wdata_i;
    m_ls   = ls_set_i   | (m_ls & ~lsr_rd_i);
    m_rx   = rx_set_i   | (m_rx & ~rbr_rd_i);
    m_thre = thre_set_i | (m_thre & ~(thr_wr_i | ack));
    for (int i = 0; i < 4; i++) begin
      bit e = (i == 2) ? (!m_s1[i] && m_s0[i]) : (m_s1[i] != m_s0[i]);
      m_d[i] = e | (m_d[i] & ~msr_rd_i);
    end
    m_s1 = m_s0;
    m_s0 = in_n;
    if (iir_rd_i && !m_reading) m_snap = live;
    m_reading = iir_rd_i;
    #1;
    exp_iir = (iir_rd_i && m_reading) ? m_snap : model_live();
    check("R3", iir_o, exp_iir);
    check("R4", irq_o, model_live() != 8'h01);
    check("R2", ier_o, {4'b0, m_ier});
    check("R10", msr_o, {~m_s1, m_d});
  endtask

  task automatic idle();
    ier_wr_i = 0; ls_set_i = 0; rx_set_i = 0; thre_set_i = 0;
    lsr_rd_i = 0; rbr_rd_i = 0; thr_wr_i = 0; msr_rd_i = 0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    m_ier = 0; m_ls = 0; m_rx = 0; m_thre = 0; m_d = 0;
    m_s0 = '1; m_s1 = '1; m_reading = 0; m_snap = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    step();
    check("R1", iir_o, 8'h01); check("R1", irq_o, 0);
    check("R1", ier_o, 8'h00); check("R1", msr_o, 8'h00);

    ier_wr_i = 1; ier_wdata_i = 4'hF; step(); idle();
    check("R2", ier_o, 8'h0F);

    thre_set_i = 1; step(); idle();
    check("R3", iir_o, 8'h02); check("R4", irq_o, 1);
    ls_set_i = 1; step(); idle();
    check("R3", iir_o, 8'h06);
    rx_set_i = 1; step(); idle();
    check("R3", iir_o, 8'h06);
    lsr_rd_i = 1; step(); idle();
    check("R8", iir_o, 8'h04);
    rbr_rd_i = 1; step(); idle();
    check("R8", iir_o, 8'h02);

    // held identifier read with a higher cause arriving mid-read
    iir_rd_i = 1; step();
    check("R7", iir_o, 8'h02);
    ls_set_i = 1; step(); idle();
    check("R7", iir_o, 8'h02); check("R4", irq_o, 1);
    step();
    check("R7", iir_o, 8'h02);
    iir_rd_i = 0; step();
    check("R7", iir_o, 8'h06);
    lsr_rd_i = 1; step(); idle();
    check("R6", iir_o, 8'h01);

    // read reporting a different code keeps holding-empty
    thre_set_i = 1; ls_set_i = 1; step(); idle();
    iir_rd_i = 1; step();
    check("R3", iir_o, 8'h06);
    iir_rd_i = 0; lsr_rd_i = 1; step(); idle();
    check("R6", iir_o, 8'h02);
    thr_wr_i = 1; step(); idle();
    check("R6", iir_o, 8'h01);

    // disabled cause recorded
    ier_wr_i = 1; ier_wdata_i = 4'h0; step(); idle();
    rx_set_i = 1; step(); idle();
    check("R11", iir_o, 8'h01); check("R11", irq_o, 0);
    ier_wr_i = 1; ier_wdata_i = 4'h1; step(); idle();
    check("R11", iir_o, 8'h04);
    rx_set_i = 1; rbr_rd_i = 1; step(); idle();
    check("R5", iir_o, 8'h04);
    rbr_rd_i = 1; step(); idle();
    check("R5", iir_o, 8'h01);

    // modem path
    ier_wr_i = 1; ier_wdata_i = 4'h8; step(); idle();
    cts_ni = 0; step();
    check("R10", msr_o, 8'h00);
    step();
    check("R10", msr_o, 8'h11); check("R9", iir_o, 8'h00); check("R4", irq_o, 1);
    msr_rd_i = 1; step(); idle();
    check("R5", msr_o, 8'h10); check("R5", iir_o, 8'h01);
    ri_ni = 0; step(); step();
    check("R9", msr_o, 8'h50);
    ri_ni = 1; step(); step();
    check("R9", msr_o, 8'h14);
    msr_rd_i = 1; step(); idle();
    check("R9", msr_o, 8'h10);
    dcd_ni = 0; dsr_ni = 0; step(); step();
    check("R10", msr_o, 8'hBA);
    msr_rd_i = 1; step(); idle();
    check("R10", msr_o, 8'hB0);
    repeat (3) step();

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule